// File: doc/BRIEF.md
# DAC Channel Update Sequencer

This block is a small bus master that sets one 16-bit value on one of eight converter channels. The converter side has only byte-wide register access. A request gives a channel, a 4-bit range code and the 16-bit value. The sequencer then runs a fixed series of byte writes and status reads on its bus. First it writes the range and a set-up command and waits for the converter to report ready. Then it loads the two data bytes, writes a load-and-convert command and waits for ready a second time.

The eight channels sit in two groups of four, each with its own four-byte register window. Channels 4 to 7 use the upper window and are encoded inside the command byte as 0 to 3. Each ready wait is bounded by a poll limit. A request that is out of range is refused at once. A per-channel shadow keeps the last value that was set successfully, and a separate readback port reads it without going to the bus.

States, each named `S_*` in the RTL:
- IDLE waits for a request. It goes to FAIL if the request is invalid, otherwise to RANGE.
- RANGE, ZERO and SETUP each make one write and then step on.
- POLL_A reads status. It goes to DLO on ready, to FAIL when the limit is spent, and otherwise stays.
- DLO, DHI and TRIG each make one write and then step on.
- POLL_B reads status. It goes to DONE on ready, to FAIL when the limit is spent, and otherwise stays.
- DONE and FAIL each last one cycle and return to IDLE.

Top module: `dac_update_seq`

## Requirements
- R1: After reset, busy, done, err, bus_wr and bus_rd are 0, and every channel's readback value is 0. No bus strobe occurs while the block is idle.
- R2: Channels 0 to 3 use bus offsets 0 to 3. Channels 4 to 7 use offsets 4 to 7 and are encoded in the command byte as channel minus 4 (bus_addr bit 2 selects the group).
- R3: The first write puts the range code, zero-extended to 8 bits, at group offset 0. The next write puts 0x00 at group offset 1.
- R4: The third write puts 0x60 OR (sub-channel << 1) at group offset 2. The block then reads group offset 3 once per cycle until bit 7 of the read data is 1. The other bits of the read data are ignored.
- R5: After the first ready, the block writes the low data byte to group offset 0, the high data byte to group offset 1, and then 0x70 OR (sub-channel << 1) to group offset 2. It then polls group offset 3 again in the same way as in R4.
- R6: Each wait allows at most POLL_LIMIT reads. If bit 7 is still 0 on the last allowed read, err pulses for one cycle, the block returns to idle and the shadow keeps its old value. If ready arrives on the last allowed read, the update still succeeds.
- R7: When the second ready is seen, done pulses for one cycle and that channel's shadow takes the new value. rb_data shows the shadow of rb_chan combinationally: the old value up to and including the cycle of the final status read, and the new value from the done cycle on.
- R8: A request with a channel of 8 or more, or a range code above 5, raises err in the next cycle and makes no bus access.
- R9: A request that arrives while busy is ignored. It makes no bus write and does not change any shadow.
- R10: done and err are never high together. Each lasts exactly one cycle, and busy is 0 in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request strobe, accepted only when idle |
| req_chan | input | 4 | Requested channel (values 8 to 15 are rejected) |
| req_range | input | 4 | Range code (valid codes are 0 to 5) |
| req_data | input | 16 | Value to set |
| busy | output | 1 | An update is in progress |
| done | output | 1 | One-cycle pulse when an update succeeds |
| err | output | 1 | One-cycle pulse on a rejected request or a timeout |
| bus_wr | output | 1 | Byte write strobe |
| bus_rd | output | 1 | Status read strobe |
| bus_addr | output | 3 | Byte offset (bit 2 selects the group) |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled in the same cycle as bus_rd |
| rb_chan | input | 3 | Readback channel select |
| rb_data | output | 16 | Shadow value of the selected channel |

## Verification
The shadow update and the readback port can fall in the same cycle: the final status read that reports ready is also the cycle in which the shadow register loads. The bench keeps rb_chan pointed at the channel it is rewriting and records rb_data on every falling edge. At the done edge it expects the new value, and on the edge just before it expects the old one. A second overlap is a new request that arrives while the block is busy; it is judged by the bus-write scoreboard staying in order and by the shadow of the requested channel staying unchanged.

// File: rtl/dac_seq_pkg.sv
`timescale 1ns/1ps
package dac_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RANGE, S_ZERO, S_SETUP, S_POLL_A,
        S_DLO, S_DHI, S_TRIG, S_POLL_B, S_DONE, S_FAIL
    } seq_state_e;

    localparam logic [7:0] CMD_SETUP = 8'h60;
    localparam logic [7:0] CMD_LOAD  = 8'h70;
    localparam logic [1:0] OFF_LOW   = 2'd0;
    localparam logic [1:0] OFF_HIGH  = 2'd1;
    localparam logic [1:0] OFF_CMD   = 2'd2;
    localparam logic [1:0] OFF_STAT  = 2'd3;
    localparam int         READY_BIT = 7;
endpackage

// File: rtl/dac_poll_timer.sv
`timescale 1ns/1ps
module dac_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // high during the last allowed poll
    assign expired = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dac_shadow_bank.sv
`timescale 1ns/1ps
module dac_shadow_bank #(
    parameter int N_CHAN = 8,
    parameter int DATA_W = 16,
    localparam int CH_W  = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   idx,
    input  logic [DATA_W-1:0] val,
    input  logic [CH_W-1:0]   rb_idx,
    output logic [DATA_W-1:0] rb_val
);
    logic [DATA_W-1:0] mem [N_CHAN];

    for (genvar g = 0; g < N_CHAN; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           mem[g] <= '0;
            else if (we && (idx == CH_W'(g)))     mem[g] <= val;
        end
    end

    assign rb_val = mem[rb_idx];
endmodule

// File: rtl/dac_seq_fsm.sv
`timescale 1ns/1ps
module dac_seq_fsm
    import dac_seq_pkg::*;
#(
    parameter int N_CHAN      = 8,
    parameter int GROUP_CHANS = 4,
    parameter int DATA_W      = 16,
    parameter int RANGE_W     = 4,
    parameter int RANGE_LAST  = 5,
    parameter int CHAN_REQ_W  = 4,
    localparam int CH_W       = $clog2(N_CHAN),
    localparam int SUB_W      = $clog2(GROUP_CHANS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [CHAN_REQ_W-1:0] req_chan,
    input  logic [RANGE_W-1:0]    req_range,
    input  logic [DATA_W-1:0]     req_data,
    input  logic [7:0]            bus_rdata,
    input  logic                  poll_expired,
    output logic                  poll_clr,
    output logic                  poll_inc,
    output logic                  bus_wr,
    output logic                  bus_rd,
    output logic [2:0]            bus_addr,
    output logic [7:0]            bus_wdata,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic                  shadow_we,
    output logic [CH_W-1:0]       shadow_idx,
    output logic [DATA_W-1:0]     shadow_val
);
    seq_state_e state, nxt;

    logic [CH_W-1:0]    cap_chan;
    logic [RANGE_W-1:0] cap_range;
    logic [DATA_W-1:0]  cap_data;
    logic               req_ok;
    logic               ready;
    logic               grp;
    logic [7:0]         sub_field;

    assign req_ok    = (req_chan < CHAN_REQ_W'(N_CHAN)) &&
                       (req_range <= RANGE_W'(RANGE_LAST));
    assign ready     = bus_rdata[READY_BIT];
    assign grp       = cap_chan[CH_W-1];
    assign sub_field = 8'(cap_chan[SUB_W-1:0]) << 1;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cap_chan  <= '0;
            cap_range <= '0;
            cap_data  <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                cap_chan  <= req_chan[CH_W-1:0];
                cap_range <= req_range;
                cap_data  <= req_data;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = req_ok ? S_RANGE : S_FAIL;
            S_RANGE:  nxt = S_ZERO;
            S_ZERO:   nxt = S_SETUP;
            S_SETUP:  nxt = S_POLL_A;
            S_POLL_A: if (ready) nxt = S_DLO;
                      else if (poll_expired) nxt = S_FAIL;
            S_DLO:    nxt = S_DHI;
            S_DHI:    nxt = S_TRIG;
            S_TRIG:   nxt = S_POLL_B;
            S_POLL_B: if (ready) nxt = S_DONE;
                      else if (poll_expired) nxt = S_FAIL;
            S_DONE:   nxt = S_IDLE;
            S_FAIL:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        bus_addr   = {grp, OFF_LOW};
        bus_wdata  = 8'h00;
        poll_clr   = 1'b1;
        poll_inc   = 1'b0;
        shadow_we  = 1'b0;
        busy       = (state != S_IDLE);
        done       = (state == S_DONE);
        err        = (state == S_FAIL);
        shadow_idx = cap_chan;
        shadow_val = cap_data;
        unique case (state)
            S_RANGE: begin
                bus_wr    = 1'b1;
                bus_addr  = {grp, OFF_LOW};
                bus_wdata = 8'(cap_range);
            end
            S_ZERO: begin
                bus_wr    = 1'b1;
                bus_addr  = {grp, OFF_HIGH};
            end
            S_SETUP: begin
                bus_wr    = 1'b1;
                bus_addr  = {grp, OFF_CMD};
                bus_wdata = CMD_SETUP | sub_field;
            end
            S_DLO: begin
                bus_wr    = 1'b1;
                bus_addr  = {grp, OFF_LOW};
                bus_wdata = cap_data[7:0];
            end
            S_DHI: begin
                bus_wr    = 1'b1;
                bus_addr  = {grp, OFF_HIGH};
                bus_wdata = cap_data[15:8];
            end
            S_TRIG: begin
                bus_wr    = 1'b1;
                bus_addr  = {grp, OFF_CMD};
                bus_wdata = CMD_LOAD | sub_field;
            end
            S_POLL_A, S_POLL_B: begin
                bus_rd    = 1'b1;
                bus_addr  = {grp, OFF_STAT};
                poll_clr  = 1'b0;
                poll_inc  = !ready;
                shadow_we = (state == S_POLL_B) && ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dac_update_seq.sv
`timescale 1ns/1ps
module dac_update_seq #(
    parameter int N_CHAN      = 8,
    parameter int GROUP_CHANS = 4,
    parameter int DATA_W      = 16,
    parameter int RANGE_W     = 4,
    parameter int RANGE_LAST  = 5,
    parameter int CHAN_REQ_W  = 4,
    parameter int POLL_LIMIT  = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [3:0]  req_chan,
    input  logic [3:0]  req_range,
    input  logic [15:0] req_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [2:0]  bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic [2:0]  rb_chan,
    output logic [15:0] rb_data
);
    localparam int CH_W = $clog2(N_CHAN);

    logic              poll_clr, poll_inc, poll_expired;
    logic              sh_we;
    logic [CH_W-1:0]   sh_idx;
    logic [DATA_W-1:0] sh_val;

    dac_seq_fsm #(
        .N_CHAN(N_CHAN), .GROUP_CHANS(GROUP_CHANS), .DATA_W(DATA_W),
        .RANGE_W(RANGE_W), .RANGE_LAST(RANGE_LAST), .CHAN_REQ_W(CHAN_REQ_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_chan(req_chan),
        .req_range(req_range), .req_data(req_data),
        .bus_rdata(bus_rdata), .poll_expired(poll_expired),
        .poll_clr(poll_clr), .poll_inc(poll_inc),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .done(done), .err(err),
        .shadow_we(sh_we), .shadow_idx(sh_idx), .shadow_val(sh_val)
    );

    dac_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(poll_clr), .inc(poll_inc), .expired(poll_expired)
    );

    dac_shadow_bank #(.N_CHAN(N_CHAN), .DATA_W(DATA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .we(sh_we), .idx(sh_idx), .val(sh_val),
        .rb_idx(rb_chan), .rb_val(rb_data)
    );
endmodule

// File: rtl/dac_update_seq_chk.sv
`timescale 1ns/1ps
module dac_update_seq_chk #(
    parameter int N_CHAN = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_chan,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_wr && !bus_rd));

    assert_poll_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr[1:0] == 2'd3 && !bus_wr));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_chan >= 4'(N_CHAN)) |=> (err && !bus_wr && !bus_rd));

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind dac_update_seq dac_update_seq_chk #(.N_CHAN(N_CHAN)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .busy(busy), .done(done), .err(err),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/dac_update_seq_tb_top.sv
`timescale 1ns/1ps
module dac_update_seq_tb_top;
    localparam int LIM = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_chan, req_range;
    logic [15:0] req_data;
    logic [2:0]  rb_chan;
    logic        busy, done, err, bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [15:0] rb_data;

    always #5 clk = ~clk;

    dac_update_seq #(.POLL_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_range(req_range), .req_data(req_data), .busy(busy), .done(done),
        .err(err), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rb_chan(rb_chan),
        .rb_data(rb_data)
    );

    // converter model: not-ready polls before ready, per phase
    int ready_a = 0, ready_b = 0;
    int polls_seen = 0, wr_cnt = 0;
    always_ff @(posedge clk) begin
        if (bus_wr) polls_seen <= 0;
        else if (bus_rd) polls_seen <= polls_seen + 1;
        if (req_valid && !busy) wr_cnt <= 0;
        else if (bus_wr) wr_cnt <= wr_cnt + 1;
    end
    assign bus_rdata = (bus_rd && polls_seen >= ((wr_cnt >= 6) ? ready_b : ready_a))
                       ? 8'h80 : 8'h7F;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [10:0] exp_q[$];
    logic [10:0] mon_act, mon_exp;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected bus writes in order
    always @(negedge clk) begin
        if (rst_n && bus_wr) begin
            mon_act = {bus_addr, bus_wdata};
            if (exp_q.size() == 0) chk(0, "R9", "unexpected bus write", int'(mon_act), 0);
            else begin
                mon_exp = exp_q.pop_front();
                chk(mon_act == mon_exp, "R2/R3/R4/R5", "bus write", int'(mon_act), int'(mon_exp));
            end
        end
    end

    task automatic push_seq(int c, int r, int d, bit full);
        logic [2:0] base;
        logic [7:0] sub;
        base = (c >= 4) ? 3'd4 : 3'd0;
        sub  = 8'((c % 4) << 1);
        exp_q.push_back({base,        8'(r)});
        exp_q.push_back({base + 3'd1, 8'h00});
        exp_q.push_back({base + 3'd2, 8'h60 | sub});
        if (full) begin
            exp_q.push_back({base,        8'(d & 255)});
            exp_q.push_back({base + 3'd1, 8'((d >> 8) & 255)});
            exp_q.push_back({base + 3'd2, 8'h70 | sub});
        end
    endtask

    // driver: one request, then judge outcome; fail_exp=1 expects err
    task automatic run(int c, int r, int d, int ra, int rbp, bit fail_exp,
                       int old, string tag);
        int n;
        logic [15:0] prev;
        ready_a = ra; ready_b = rbp;
        @(negedge clk);
        req_valid = 1; req_chan = 4'(c); req_range = 4'(r); req_data = 16'(d);
        rb_chan = 3'(c & 7);
        @(negedge clk);
        req_valid = 0;
        n = 0; prev = rb_data;
        while (!(done || err) && n < 400) begin
            prev = rb_data;
            @(negedge clk);
            n++;
        end
        if (!fail_exp) begin
            chk(done && !err, tag, "done pulse", {done, err}, 2);
            chk(prev == 16'(old), "R7", "readback before update", prev, old);
            chk(rb_data == 16'(d), "R7", "readback at done", rb_data, d);
        end else begin
            chk(err && !done, tag, "err pulse", {done, err}, 1);
            if (c < 8) chk(rb_data == 16'(old), tag, "shadow kept", rb_data, old);
        end
        @(negedge clk);
        chk(!done && !err && !busy, "R10", "single pulse then idle", {busy, done, err}, 0);
        chk(exp_q.size() == 0, tag, "pending expected writes", exp_q.size(), 0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_chan = 0; req_range = 0; req_data = 0; rb_chan = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !err && !bus_wr && !bus_rd, "R1", "reset outputs",
            {busy, done, err, bus_wr, bus_rd}, 0);
        for (int i = 0; i < 8; i++) begin
            rb_chan = 3'(i); #1;
            chk(rb_data == 16'h0, "R1", "reset shadow", rb_data, 0);
        end

        // R3/R4/R5 basic update, lower group
        push_seq(2, 3, 16'hA55A, 1);
        run(2, 3, 16'hA55A, 0, 0, 0, 0, "R5");
        // R2 upper group with waits
        push_seq(6, 5, 16'h1234, 1);
        run(6, 5, 16'h1234, 3, 2, 0, 0, "R2");
        // R6 ready on last allowed poll
        push_seq(4, 0, 16'hFFFF, 1);
        run(4, 0, 16'hFFFF, LIM - 1, LIM - 1, 0, 0, "R6");
        // R6 timeout in first wait
        push_seq(1, 2, 16'hBEEF, 0);
        run(1, 2, 16'hBEEF, LIM, 0, 1, 0, "R6");
        // R6 timeout in second wait
        push_seq(7, 1, 16'hCAFE, 1);
        run(7, 1, 16'hCAFE, 0, LIM, 1, 0, "R6");
        // R8 rejections: channel 9, range 6
        run(9, 1, 16'h1111, 0, 0, 1, 0, "R8");
        run(0, 6, 16'h2222, 0, 0, 1, 0, "R8");
        // R7 rewrite of channel 2: old value visible until done cycle
        push_seq(2, 4, 16'h0F0F, 1);
        run(2, 4, 16'h0F0F, 1, 1, 0, 16'hA55A, "R7");

        // R9 request while busy is ignored
        ready_a = 5; ready_b = 0;
        push_seq(3, 1, 16'h4321, 1);
        @(negedge clk);
        req_valid = 1; req_chan = 4'd3; req_range = 4'd1; req_data = 16'h4321;
        @(negedge clk);
        req_chan = 4'd5; req_data = 16'h7777;
        repeat (2) @(negedge clk);
        req_valid = 0;
        repeat (30) @(negedge clk);
        chk(!busy && exp_q.size() == 0, "R9", "first update finished alone",
            exp_q.size(), 0);
        rb_chan = 3'd5; #1;
        chk(rb_data == 16'h0, "R9", "ignored channel shadow", rb_data, 0);
        rb_chan = 3'd3; #1;
        chk(rb_data == 16'h4321, "R9", "accepted channel shadow", rb_data, 16'h4321);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule